// File: doc/BRIEF.md
# Serial Receiver with Interrupt Gating and Standby Wakeup

This block receives asynchronous serial characters on a single input line. A sample strobe running at sixteen times the bit rate drives a small framing state machine that finds the start bit, takes each data bit at its midpoint and checks the stop bit. Characters carry 8 or 9 data bits, least significant bit first. A good character is stored in the data output and raises a receive-full flag. A separate detector raises an idle-line flag once the line has stayed high for a whole character time after a character.

Both flags share one interrupt request output, each through its own enable. A standby bit lets one receiver on a shared multidrop line ignore traffic meant for other receivers. While standby is set, the interrupt request is held low and characters that do not wake the receiver are dropped. The wake condition is chosen by a mode input. It is either an idle line or a character whose top data bit is 1 (an address character). The wake event clears the standby bit by itself.

The framing machine has four states. RX_WAIT watches for a falling edge. RX_START checks the start bit at its middle. RX_DATA shifts in the data bits. RX_STOP checks the stop bit. The transitions are:
- RX_WAIT to RX_START on a high-to-low change between two strobes.
- RX_START to RX_DATA if the line is still low at the eighth strobe.
- RX_START back to RX_WAIT if the line is high at the eighth strobe.
- RX_DATA to RX_STOP after the last data bit is taken.
- RX_STOP to RX_WAIT at the stop-bit midpoint, whether the stop bit was good or bad.
- Any state to RX_WAIT whenever the receiver is disabled.

Top module: `uart_rx_wake`

## Requirements
- R1: Each character is framed as a low start bit, then the data bits LSB first, then a high stop bit, with each bit 16 strobes long. A low level counts as a start bit only if it is still low at the eighth strobe after the falling edge. A shorter low pulse produces no character. In 8-bit mode a good character appears on `rx_data[7:0]` with `rx_data[8]` = 0, and `rx_full` becomes 1.
- R2: When `nine_bit` = 1, characters carry nine data bits. The ninth received bit appears on `rx_data[8]`.
- R3: `irq` is 1 because of `rx_full` only while the receive-interrupt enable is 1. That enable is written through `ctl_rie` on a `ctl_wr` strobe.
- R4: `idle_flag` becomes 1 once the line has been high for 10 bit times (11 in 9-bit mode), measured from the stop bit of a received character. It is raised once per character. It asserts `irq` only while the idle-interrupt enable (`ctl_iie`) is 1.
- R5: A `data_rd` strobe clears `rx_full`. `idle_flag` clears only on a `data_rd` that comes after a `stat_rd` made while `idle_flag` was 1. A `data_rd` alone leaves `idle_flag` set.
- R6: Writing the receiver enable to 0 stops reception. `rx_full`, `rx_data` and `idle_flag` keep their values.
- R7: A `ctl_wr` does not change `rx_enable` while `port_en` is 0.
- R8: Reset clears the receiver enable, standby, both interrupt enables and both flags.
- R9: While `standby` = 1, `irq` is 0. Characters that do not wake the receiver set no flag, and an idle line sets no flag.
- R10: With `wake_sel` = 1, an address character clears `standby` and is stored with `rx_full` set. An address character is one whose top data bit is 1: bit 7 in 8-bit mode, bit 8 in 9-bit mode.
- R11: With `wake_sel` = 0, an idle line clears `standby` and leaves `idle_flag` at 0.
- R12: A character whose stop bit samples low is discarded, and `rx_full` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, high when idle |
| nine_bit | input | 1 | 1 = nine data bits per character |
| wake_sel | input | 1 | Wake condition: 1 = address character, 0 = idle line |
| port_en | input | 1 | Global enable; receiver-enable writes are ignored while 0 |
| ctl_wr | input | 1 | Strobe that writes the four control fields |
| ctl_rx_en | input | 1 | Receiver enable value to write |
| ctl_rie | input | 1 | Receive-interrupt enable value to write |
| ctl_iie | input | 1 | Idle-interrupt enable value to write |
| ctl_standby | input | 1 | Standby value to write |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| rx_data | output | 9 | Last stored character |
| rx_full | output | 1 | Receive-full flag |
| idle_flag | output | 1 | Idle-line flag |
| rx_enable | output | 1 | Current receiver enable |
| standby | output | 1 | Current standby bit |
| irq | output | 1 | Receiver interrupt request |

## Verification
The hardest situation to reach is a wake decision that depends on the history of the line. An idle wake needs a character received during standby to arm the idle counter. That character must be dropped, and the wake must then come without raising the idle flag. The stimulus first sends a non-address character in standby, checks that nothing was stored and that standby still holds, then waits out a full character time of high line. A separate run shows the opposite case: with the address wake mode selected, an idle line does not end standby.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        RX_WAIT,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       enable,
    input  logic       nine,
    output logic       char_done,
    output logic [8:0] char_data,
    output logic       quiet
);
    localparam int TW = $clog2(OSR);
    localparam logic [TW-1:0] MID  = TW'(OSR / 2 - 1);
    localparam logic [TW-1:0] LAST = TW'(OSR - 1);

    rx_state_t       state, nxt;
    logic [TW-1:0]   tcnt;
    logic [3:0]      bcnt;
    logic [8:0]      shreg;
    logic            rxd_prev;
    logic [3:0]      last_bit;

    assign last_bit = nine ? 4'd8 : 4'd7;
    assign quiet    = (state == RX_WAIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_WAIT;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = RX_WAIT;
        end else if (tick) begin
            unique case (state)
                RX_WAIT:  if (!rxd && rxd_prev) nxt = RX_START;
                RX_START: if (tcnt == MID) nxt = rxd ? RX_WAIT : RX_DATA;
                RX_DATA:  if (tcnt == LAST && bcnt == last_bit) nxt = RX_STOP;
                RX_STOP:  if (tcnt == LAST) nxt = RX_WAIT;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            bcnt      <= '0;
            shreg     <= '0;
            rxd_prev  <= 1'b1;
            char_done <= 1'b0;
            char_data <= '0;
        end else begin
            char_done <= 1'b0;
            if (tick) begin
                rxd_prev <= rxd;
                if (enable) begin
                    unique case (state)
                        RX_WAIT: tcnt <= TW'(1);
                        RX_START: begin
                            bcnt <= '0;
                            tcnt <= (tcnt == MID) ? '0 : tcnt + 1'b1;
                        end
                        RX_DATA: begin
                            if (tcnt == LAST) begin
                                tcnt  <= '0;
                                bcnt  <= bcnt + 1'b1;
                                shreg <= nine ? {rxd, shreg[8:1]}
                                              : {1'b0, rxd, shreg[7:1]};
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end
                        RX_STOP: begin
                            if (tcnt == LAST) begin
                                tcnt <= '0;
                                if (rxd) begin
                                    char_done <= 1'b1;
                                    char_data <= shreg;
                                end
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic enable,
    input  logic nine,
    input  logic quiet,
    input  logic char_done,
    output logic idle_hit
);
    localparam int CW = $clog2(11 * OSR + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          armed;

    assign limit = nine ? CW'(11 * OSR - 1) : CW'(10 * OSR - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            armed    <= 1'b0;
            idle_hit <= 1'b0;
        end else begin
            idle_hit <= 1'b0;
            if (!enable) begin
                cnt <= '0;
            end else if (char_done) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (!quiet) begin
                cnt <= '0;
            end else if (tick) begin
                if (!rxd) begin
                    cnt <= '0;
                end else if (armed) begin
                    if (cnt == limit) begin
                        idle_hit <= 1'b1;
                        armed    <= 1'b0;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_en,
    input  logic       ctl_wr,
    input  logic       ctl_rx_en,
    input  logic       ctl_rie,
    input  logic       ctl_iie,
    input  logic       ctl_standby,
    input  logic       wake_sel,
    input  logic       nine,
    input  logic       char_done,
    input  logic [8:0] char_data,
    input  logic       idle_hit,
    input  logic       stat_rd,
    input  logic       data_rd,
    output logic       rx_enable,
    output logic       rie,
    output logic       iie,
    output logic       standby,
    output logic       rx_full,
    output logic       idle_flag,
    output logic [8:0] rx_data,
    output logic       irq
);
    logic addr_char, accept, wake_evt, stat_seen;

    assign addr_char = nine ? char_data[8] : char_data[7];
    assign accept    = char_done && rx_enable && (!standby || (wake_sel && addr_char));
    assign wake_evt  = standby && ((accept && wake_sel) || (idle_hit && !wake_sel));
    assign irq       = !standby && ((rie && rx_full) || (iie && idle_flag));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_enable <= 1'b0;
            rie       <= 1'b0;
            iie       <= 1'b0;
            standby   <= 1'b0;
            rx_full   <= 1'b0;
            idle_flag <= 1'b0;
            stat_seen <= 1'b0;
            rx_data   <= '0;
        end else begin
            if (ctl_wr) begin
                rie <= ctl_rie;
                iie <= ctl_iie;
                if (port_en) rx_enable <= ctl_rx_en;
            end
            if (ctl_wr)        standby <= ctl_standby;
            else if (wake_evt) standby <= 1'b0;

            if (accept) begin
                rx_full <= 1'b1;
                rx_data <= char_data;
            end else if (data_rd) begin
                rx_full <= 1'b0;
            end

            if (idle_hit && !standby)        idle_flag <= 1'b1;
            else if (data_rd && stat_seen)   idle_flag <= 1'b0;

            if (stat_rd && idle_flag) stat_seen <= 1'b1;
            else if (data_rd)         stat_seen <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       nine_bit,
    input  logic       wake_sel,
    input  logic       port_en,
    input  logic       ctl_wr,
    input  logic       ctl_rx_en,
    input  logic       ctl_rie,
    input  logic       ctl_iie,
    input  logic       ctl_standby,
    input  logic       stat_rd,
    input  logic       data_rd,
    output logic [8:0] rx_data,
    output logic       rx_full,
    output logic       idle_flag,
    output logic       rx_enable,
    output logic       standby,
    output logic       irq
);
    logic       char_done, quiet, idle_hit;
    logic [8:0] char_data;
    logic       rie_q, iie_q;

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .enable(rx_enable), .nine(nine_bit),
        .char_done(char_done), .char_data(char_data), .quiet(quiet)
    );

    uart_rx_idle #(.OSR(OSR)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .enable(rx_enable), .nine(nine_bit), .quiet(quiet),
        .char_done(char_done), .idle_hit(idle_hit)
    );

    uart_rx_flags u_flags (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .ctl_wr(ctl_wr),
        .ctl_rx_en(ctl_rx_en), .ctl_rie(ctl_rie), .ctl_iie(ctl_iie),
        .ctl_standby(ctl_standby), .wake_sel(wake_sel), .nine(nine_bit),
        .char_done(char_done), .char_data(char_data), .idle_hit(idle_hit),
        .stat_rd(stat_rd), .data_rd(data_rd),
        .rx_enable(rx_enable), .rie(rie_q), .iie(iie_q), .standby(standby),
        .rx_full(rx_full), .idle_flag(idle_flag), .rx_data(rx_data), .irq(irq)
    );
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic data_rd,
    input logic rx_enable,
    input logic standby,
    input logic rx_full,
    input logic idle_flag,
    input logic irq,
    input logic rie,
    input logic iie
);
    // R9: standby masks the request
    p_standby_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !irq);

    // R3 and R4: a request always has an enabled, set flag behind it
    p_irq_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((rie && rx_full) || (iie && idle_flag)));

    // R5: flags hold until a data read
    p_full_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !data_rd) |=> rx_full);
    p_idle_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !data_rd) |=> idle_flag);

    // R6: a disabled receiver stores nothing new
    p_off_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !data_rd) |=> $stable(rx_full));

    // R7: enable is locked while the port is off
    p_en_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> $stable(rx_enable));

    // R8: state leaving reset
    p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rx_enable && !standby && !rie && !iie && !rx_full && !idle_flag));
endmodule

bind uart_rx_wake uart_rx_wake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .data_rd(data_rd),
    .rx_enable(rx_enable), .standby(standby), .rx_full(rx_full),
    .idle_flag(idle_flag), .irq(irq), .rie(rie_q), .iie(iie_q)
);

// File: tb/uart_rx_wake_bench.sv
module uart_rx_wake_bench;
    localparam int BIT = 32; // 16 strobes, one every second clock

    logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1;
    logic nine_bit = 0, wake_sel = 0, port_en = 0;
    logic ctl_wr = 0, ctl_rx_en = 0, ctl_rie = 0, ctl_iie = 0, ctl_standby = 0;
    logic stat_rd = 0, tb_rd = 0, mon_rd = 0, mon_en = 0;
    logic data_rd;
    logic [8:0] rx_data;
    logic rx_full, idle_flag, rx_enable, standby, irq;
    int checks = 0, errors = 0;
    bit timed_out = 0;
    int expq[$];

    assign data_rd = tb_rd | mon_rd;
    always #10 clk = ~clk;

    uart_rx_wake u_uart_rx_wake (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .nine_bit(nine_bit), .wake_sel(wake_sel), .port_en(port_en),
        .ctl_wr(ctl_wr), .ctl_rx_en(ctl_rx_en), .ctl_rie(ctl_rie),
        .ctl_iie(ctl_iie), .ctl_standby(ctl_standby),
        .stat_rd(stat_rd), .data_rd(data_rd),
        .rx_data(rx_data), .rx_full(rx_full), .idle_flag(idle_flag),
        .rx_enable(rx_enable), .standby(standby), .irq(irq)
    );

    initial forever @(negedge clk) tick16 = ~tick16;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_rd) begin
            mon_rd = 0;
        end else if (mon_en && rx_full) begin
            if (expq.size() == 0) begin
                chk("R1 unexpected character", int'(rx_data), -1);
            end else begin
                int e;
                e = expq.pop_front();
                chk(nine_bit ? "R2 scoreboard" : "R1 scoreboard", int'(rx_data), e);
            end
            mon_rd = 1;
        end
    end

    task automatic ctl(input bit en, input bit ri, input bit ii, input bit sb);
        @(negedge clk);
        ctl_rx_en = en; ctl_rie = ri; ctl_iie = ii; ctl_standby = sb; ctl_wr = 1;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT) @(negedge clk);
    endtask

    task automatic send(input int d, input bit nine, input bit stop_ok, input bit push);
        if (push) expq.push_back(d);
        rxd = 0; repeat (BIT) @(negedge clk);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rxd = d[i]; repeat (BIT) @(negedge clk);
        end
        rxd = stop_ok; repeat (BIT) @(negedge clk);
        rxd = 1;
    endtask

    task automatic rd_data();
        @(negedge clk); tb_rd = 1; @(negedge clk); tb_rd = 0;
    endtask

    task automatic rd_stat();
        @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
    endtask

    task automatic run();
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8 rx_enable", rx_enable, 0);
        chk("R8 standby", standby, 0);
        chk("R8 rx_full", rx_full, 0);
        chk("R8 idle_flag", idle_flag, 0);
        chk("R8 irq", irq, 0);

        ctl(1, 1, 0, 0);
        chk("R7 enable locked", rx_enable, 0);
        port_en = 1;
        ctl(1, 0, 0, 0);
        chk("R7 enable written", rx_enable, 1);
        wait_bits(2);

        mon_en = 1;
        send(9'h0A5, 0, 1, 1);
        send(9'h03C, 0, 1, 1);
        send(9'h081, 0, 1, 1);
        wait_bits(12);
        chk("R4 idle raised", idle_flag, 1);
        chk("R4 idle masked", irq, 0);
        ctl(1, 0, 1, 0);
        chk("R4 idle irq", irq, 1);
        rd_data();
        chk("R5 data read alone", idle_flag, 1);
        rd_stat(); rd_data();
        chk("R5 idle cleared", idle_flag, 0);
        chk("R4 irq dropped", irq, 0);
        wait_bits(14);
        chk("R4 once per character", idle_flag, 0);
        mon_en = 0;

        ctl(1, 0, 0, 0);
        send(9'h05A, 0, 1, 0);
        chk("R1 full", rx_full, 1);
        chk("R1 data", int'(rx_data), 'h05A);
        chk("R3 masked", irq, 0);
        ctl(1, 1, 0, 0);
        chk("R3 enabled", irq, 1);
        rd_data();
        chk("R5 full cleared", rx_full, 0);
        chk("R3 irq dropped", irq, 0);
        wait_bits(12);
        rd_stat(); rd_data();

        // short low pulse
        rxd = 0; repeat (6) @(negedge clk); rxd = 1;
        wait_bits(12);
        chk("R1 glitch rejected", rx_full, 0);

        send(9'h077, 0, 0, 0);
        wait_bits(1);
        chk("R12 bad stop", rx_full, 0);

        nine_bit = 1;
        mon_en = 1;
        send(9'h1C3, 1, 1, 1);
        send(9'h0FF, 1, 1, 1);
        wait_bits(14);
        mon_en = 0;
        rd_stat(); rd_data();
        chk("R2 queue drained", expq.size(), 0);
        chk("R5 idle cleared 9-bit", idle_flag, 0);
        nine_bit = 0;

        send(9'h042, 0, 1, 0);
        ctl(0, 1, 0, 0);
        chk("R6 disabled", rx_enable, 0);
        chk("R6 full kept", rx_full, 1);
        chk("R6 data kept", int'(rx_data), 'h042);
        wait_bits(14);
        chk("R6 idle kept", idle_flag, 0);
        chk("R6 full still kept", rx_full, 1);
        rd_data();
        send(9'h024, 0, 1, 0);
        chk("R6 no reception", rx_full, 0);

        wake_sel = 1;
        ctl(1, 1, 0, 0);
        wait_bits(1);
        send(9'h011, 0, 1, 0);
        chk("R3 pending irq", irq, 1);
        ctl(1, 1, 0, 1);
        chk("R9 standby set", standby, 1);
        chk("R9 irq masked", irq, 0);
        rd_data();
        wait_bits(12);
        chk("R9 idle ignored", idle_flag, 0);
        chk("R9 still standby", standby, 1);
        send(9'h041, 0, 1, 0);
        chk("R9 dropped", rx_full, 0);
        chk("R10 no wake bit7=0", standby, 1);
        send(9'h0C2, 0, 1, 0);
        chk("R10 woke", standby, 0);
        chk("R10 stored", rx_full, 1);
        chk("R10 data", int'(rx_data), 'h0C2);
        chk("R10 irq", irq, 1);
        rd_data();
        wait_bits(12);
        rd_stat(); rd_data();

        nine_bit = 1;
        ctl(1, 1, 0, 1);
        send(9'h080, 1, 1, 0);
        chk("R10 bit8=0 no wake", standby, 1);
        chk("R10 bit8=0 dropped", rx_full, 0);
        send(9'h101, 1, 1, 0);
        chk("R10 bit8 woke", standby, 0);
        chk("R10 bit8 data", int'(rx_data), 'h101);
        rd_data();

        nine_bit = 0;
        wake_sel = 0;
        ctl(1, 1, 1, 1);
        wait_bits(14);
        chk("R11 idle woke", standby, 0);
        chk("R11 no flag", idle_flag, 0);
        ctl(1, 1, 1, 1);
        send(9'h066, 0, 1, 0);
        chk("R9 dropped idle mode", rx_full, 0);
        chk("R11 still standby", standby, 1);
        wait_bits(12);
        chk("R11 woke after char", standby, 0);
        chk("R11 flag clear", idle_flag, 0);
        chk("R11 irq", irq, 0);
    endtask

    initial begin
        fork
            run();
            begin repeat (150000) @(posedge clk); timed_out = 1; end
        join_any
        if (timed_out) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule